// File: doc/BRIEF.md
# Stacked Issue Arbiter with Port Reservation

This block picks which instructions of a 32-entry issue window go to execution in a cycle. It also decides which register source feeds each chosen instruction's two operands. There are two sources. One is a small, fast register cache, reached through a few read-port pairs. The other is the complete register file, reached through the remaining read-port pairs. An instruction may use the cache only if both of its operands are held there; the window marks such an entry "cache-eligible".

Selection is done by a chain of identical arbiter stages. Each stage stands for one functional-unit slot. A stage looks at the requests that are still pending and takes the lowest-index one. It then tries to reserve a read-port pair for that instruction. A cache-eligible winner takes a cache pair if one is free. Otherwise the winner takes a full-file pair if one is free. If neither is possible, the stage grants nothing. A granted entry is removed from the pending set that is passed to the next stage.

Port occupancy travels down the chain as two busy vectors, one for cache pairs and one for full-file pairs. At each stage the lowest clear bit is set when that source is reserved, so each vector fills from the bottom up. A source is available to the next stage while its vector is not yet all ones. Both vectors start empty in every cycle. The combined grant pattern and the port choices are registered, so they appear one clock after the requests.

Top module: `stacked_issue_arb`

## Requirements
- R1: While reset is asserted, and after it, until the first request is sampled, `grant_o` and `use_rc_o` are all zero.
- R2: Grant order follows entry index.
  - Each stage grants at most one entry, and only an entry that is still pending.
  - The entry considered is the lowest pending index; bit i of every vector is entry i.
  - No entry is granted twice, and no entry without a request is granted.
- R3: When the entry a stage considers is cache-eligible and a cache pair is still free, it is granted with `use_rc_o` bit = 1 (cache).
- R4: A winner takes a full-file pair, with `use_rc_o` bit = 0, in two cases. One is a cache-eligible winner when all cache pairs are taken. The other is a winner that is not cache-eligible. In both cases a full-file pair must still be free.
- R5: Per cycle at most `RC_PAIRS` (5) entries are granted with the cache and at most `FR_PAIRS` (3) with the full file. At most `STAGES` (8) entries are granted in total.
- R6: Suppose the lowest pending entry is not cache-eligible and no full-file pair is free. Then that stage and every later stage grant nothing in that cycle, even for higher cache-eligible entries.
- R7: Outputs reflect the requests sampled at the previous rising edge. Port occupancy does not carry from one cycle to the next.
- R8: `use_rc_o` bit i is 1 only when `grant_o` bit i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 32 | Ready request per window entry |
| cache_i | input | 32 | Entry has both operands in the register cache |
| grant_o | output | 32 | Entry issued this cycle (registered) |
| use_rc_o | output | 32 | 1 = granted entry reads the cache, 0 = full file |

## Verification
Faults inside the stack show up at the ports one clock after the requests are presented. The symptoms depend on which part is wrong:
- A busy vector that fills incorrectly shows as too many or too few grants on one port type.
- A wrong per-stage priority shows as a granted higher index while a lower pending entry is skipped.
- A pending mask that is not cleared shows as an entry granted by two stages. The visible effect is fewer total grants than the reference predicts.

The directed scenarios are built so that each of these mistakes changes the registered grant or port-choice pattern in that same cycle. They also include the blocking case, where a stall at one stage must hide every later entry.

// File: rtl/issue_arb_pkg.sv
// Package: shared sizing defaults and helpers for the stacked issue arbiter.
// Assumes the window size is a multiple of the leaf width.
package issue_arb_pkg;
    localparam int DEF_ENTRIES  = 32;
    localparam int DEF_LEAF     = 4;
    localparam int DEF_STAGES   = 8;
    localparam int DEF_RC_PAIRS = 5;
    localparam int DEF_FR_PAIRS = 3;
endpackage

// File: rtl/pair_busy_mask.sv
// Module: pair_busy_mask
// Marks one more port pair as taken by setting the lowest clear bit of a
// busy vector when reserve is high. The vector therefore fills from the
// bottom up, like a thermometer. Purely combinational.
// Assumes the incoming vector is already thermometer-coded.
module pair_busy_mask #(
    parameter int W = 4
) (
    input  logic         reserve_i,
    input  logic [W-1:0] busy_i,
    output logic [W-1:0] busy_o
);
    logic [W-1:0] lowest_free;

    // Isolate the lowest zero bit of the incoming busy vector.
    always_comb lowest_free = ~busy_i & (busy_i + {{(W-1){1'b0}}, 1'b1});

    // Apply the reservation when requested.
    always_comb busy_o = reserve_i ? (busy_i | lowest_free) : busy_i;
endmodule

// File: rtl/leaf_port_arb.sv
// Module: leaf_port_arb
// A four-request leaf cell that combines priority with port matching.
// When enabled, it takes its lowest-index active request. The request is
// granted if it is cache-eligible and a cache pair is available, or else if
// a full-file pair is available. The cell reports which pair type it reserved.
// Assumes at most one leaf in a stage is enabled at a time.
module leaf_port_arb #(
    parameter int N = 4
) (
    input  logic         en_i,
    input  logic         avail_rc_i,
    input  logic         avail_fr_i,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] cache_i,
    output logic [N-1:0] grant_o,
    output logic [N-1:0] use_rc_o,
    output logic         take_rc_o,
    output logic         take_fr_o
);
    logic [N-1:0] first;
    logic         first_cache;
    logic         any_req;

    // Fixed-priority pick of the lowest active request.
    always_comb begin
        first = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) first = '0;
            if (req_i[i]) first[i] = 1'b1;
        end
    end

    // Summary flags for the winner.
    always_comb begin
        any_req     = |req_i;
        first_cache = |(first & cache_i);
    end

    // Cache request match: choose the pair type for the winner.
    always_comb begin
        take_rc_o = en_i && any_req && first_cache && avail_rc_i;
        take_fr_o = en_i && any_req && avail_fr_i && !take_rc_o;
    end

    // Per-entry grant and port choice.
    always_comb begin
        grant_o  = (take_rc_o || take_fr_o) ? first : '0;
        use_rc_o = take_rc_o ? first : '0;
    end
endmodule

// File: rtl/arb_stage.sv
// Module: arb_stage
// One functional-unit arbiter stage of the stack. The root picks the lowest
// leaf group that holds a pending request and enables only that leaf. Port
// availability is the NAND of each incoming busy vector. The busy vectors are
// passed on to the next stage, updated by the reservation made here.
// Assumes ENTRIES is a multiple of LEAF.
module arb_stage #(
    parameter int ENTRIES  = 32,
    parameter int LEAF     = 4,
    parameter int RC_PAIRS = 5,
    parameter int FR_PAIRS = 3
) (
    input  logic [ENTRIES-1:0]  pend_i,
    input  logic [ENTRIES-1:0]  cache_i,
    input  logic [RC_PAIRS-1:0] busy_rc_i,
    input  logic [FR_PAIRS-1:0] busy_fr_i,
    output logic [ENTRIES-1:0]  grant_o,
    output logic [ENTRIES-1:0]  use_rc_o,
    output logic [RC_PAIRS-1:0] busy_rc_o,
    output logic [FR_PAIRS-1:0] busy_fr_o
);
    localparam int GROUPS = ENTRIES / LEAF;

    logic [GROUPS-1:0] grp_any;
    logic [GROUPS-1:0] grp_en;
    logic [GROUPS-1:0] grp_rc;
    logic [GROUPS-1:0] grp_fr;
    logic              avail_rc;
    logic              avail_fr;
    logic              reserve_rc;
    logic              reserve_fr;

    // A source is available while at least one of its pairs is clear.
    always_comb begin
        avail_rc = ~&busy_rc_i;
        avail_fr = ~&busy_fr_i;
    end

    // Request-presence flag for each leaf group.
    always_comb begin
        for (int g = 0; g < GROUPS; g++) grp_any[g] = |pend_i[g*LEAF +: LEAF];
    end

    // Root priority: enable only the lowest group that has a request.
    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int g = 0; g < GROUPS; g++) begin
            grp_en[g] = grp_any[g] && !seen;
            seen      = seen || grp_any[g];
        end
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_leaf
        leaf_port_arb #(.N(LEAF)) u_leaf (
            .en_i       (grp_en[g]),
            .avail_rc_i (avail_rc),
            .avail_fr_i (avail_fr),
            .req_i      (pend_i[g*LEAF +: LEAF]),
            .cache_i    (cache_i[g*LEAF +: LEAF]),
            .grant_o    (grant_o[g*LEAF +: LEAF]),
            .use_rc_o   (use_rc_o[g*LEAF +: LEAF]),
            .take_rc_o  (grp_rc[g]),
            .take_fr_o  (grp_fr[g])
        );
    end

    // Gather the reservation made by whichever leaf won.
    always_comb begin
        reserve_rc = |grp_rc;
        reserve_fr = |grp_fr;
    end

    pair_busy_mask #(.W(RC_PAIRS)) u_rc_mask (
        .reserve_i (reserve_rc),
        .busy_i    (busy_rc_i),
        .busy_o    (busy_rc_o)
    );

    pair_busy_mask #(.W(FR_PAIRS)) u_fr_mask (
        .reserve_i (reserve_fr),
        .busy_i    (busy_fr_i),
        .busy_o    (busy_fr_o)
    );
endmodule

// File: rtl/stacked_issue_arb.sv
// Module: stacked_issue_arb (top)
// Chains STAGES arbiter stages. Each stage sees the pending requests left by
// the previous one, together with the busy vectors as updated so far. Both
// busy vectors start empty in every cycle. The combined grants and port
// choices are registered.
// Assumes requests are stable around the rising edge.
module stacked_issue_arb
    import issue_arb_pkg::*;
#(
    parameter int ENTRIES  = DEF_ENTRIES,
    parameter int LEAF     = DEF_LEAF,
    parameter int STAGES   = DEF_STAGES,
    parameter int RC_PAIRS = DEF_RC_PAIRS,
    parameter int FR_PAIRS = DEF_FR_PAIRS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] req_i,
    input  logic [ENTRIES-1:0] cache_i,
    output logic [ENTRIES-1:0] grant_o,
    output logic [ENTRIES-1:0] use_rc_o
);
    logic [ENTRIES-1:0]  pend    [STAGES+1];
    logic [RC_PAIRS-1:0] busy_rc [STAGES+1];
    logic [FR_PAIRS-1:0] busy_fr [STAGES+1];
    logic [ENTRIES-1:0]  stg_grant [STAGES];
    logic [ENTRIES-1:0]  stg_rc    [STAGES];
    logic [ENTRIES-1:0]  grant_all;
    logic [ENTRIES-1:0]  rc_all;

    // Stack entry point: all requests pending, all ports free.
    always_comb begin
        pend[0]    = req_i;
        busy_rc[0] = '0;
        busy_fr[0] = '0;
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        arb_stage #(
            .ENTRIES  (ENTRIES),
            .LEAF     (LEAF),
            .RC_PAIRS (RC_PAIRS),
            .FR_PAIRS (FR_PAIRS)
        ) u_stage (
            .pend_i    (pend[s]),
            .cache_i   (cache_i),
            .busy_rc_i (busy_rc[s]),
            .busy_fr_i (busy_fr[s]),
            .grant_o   (stg_grant[s]),
            .use_rc_o  (stg_rc[s]),
            .busy_rc_o (busy_rc[s+1]),
            .busy_fr_o (busy_fr[s+1])
        );

        // Remove this stage's winner before the next stage.
        always_comb pend[s+1] = pend[s] & ~stg_grant[s];

        // R2
        stage_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(stg_grant[s]) && ((stg_grant[s] & ~pend[s]) == '0));

        // R3
        cache_pref_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((|(stg_grant[s] & cache_i)) && !(&busy_rc[s])) |-> (|stg_rc[s]));

        // R5
        thermo_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((busy_rc[s+1] & (busy_rc[s+1] + 1'b1)) == '0) &&
            ((busy_fr[s+1] & (busy_fr[s+1] + 1'b1)) == '0));
    end

    // Merge per-stage results.
    always_comb begin
        grant_all = '0;
        rc_all    = '0;
        for (int s = 0; s < STAGES; s++) begin
            grant_all = grant_all | stg_grant[s];
            rc_all    = rc_all | stg_rc[s];
        end
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_o  <= '0;
            use_rc_o <= '0;
        end else begin
            grant_o  <= grant_all;
            use_rc_o <= rc_all;
        end
    end

    // R2
    grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~$past(req_i)) == '0);

    // R5
    rc_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o & use_rc_o) <= RC_PAIRS);

    // R5
    fr_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o & ~use_rc_o) <= FR_PAIRS);

    // R8
    choice_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_rc_o & ~grant_o) == '0);
endmodule

// File: tb/test_stacked_issue_arb.sv
module test_stacked_issue_arb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_i = '0;
    logic [31:0] cache_i = '0;
    logic [31:0] grant_o;
    logic [31:0] use_rc_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    stacked_issue_arb i_stacked_issue_arb (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .cache_i(cache_i),
        .grant_o(grant_o), .use_rc_o(use_rc_o)
    );

    // Sequential reference: 8 stages, 5 cache pairs, 3 full-file pairs.
    function automatic void ref_model(input logic [31:0] r, input logic [31:0] c,
                                      output logic [31:0] g, output logic [31:0] u);
        logic [31:0] p;
        int rc;
        int fr;
        bit stop;
        p = r; rc = 5; fr = 3; g = '0; u = '0; stop = 0;
        for (int s = 0; s < 8; s++) begin
            int idx;
            idx = -1;
            for (int i = 31; i >= 0; i--) if (p[i]) idx = i;
            if (idx < 0 || stop) break;
            if (c[idx] && rc > 0) begin
                g[idx] = 1'b1; u[idx] = 1'b1; rc--; p[idx] = 1'b0;
            end else if (fr > 0) begin
                g[idx] = 1'b1; fr--; p[idx] = 1'b0;
            end else stop = 1;
        end
    endfunction

    task automatic check_vec(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one pattern, wait for the register, compare with the reference.
    task automatic apply(input string tag, input logic [31:0] r, input logic [31:0] c);
        logic [31:0] eg;
        logic [31:0] eu;
        ref_model(r, c, eg, eu);
        @(negedge clk); req_i = r; cache_i = c;
        @(posedge clk); @(negedge clk);
        check_vec({tag, " grant"}, grant_o, eg);
        check_vec({tag, " use_rc"}, use_rc_o, eu);
    endtask

    task automatic t_reset();
        @(negedge clk); req_i = 32'hFFFF_FFFF; cache_i = 32'hFFFF_FFFF;
        @(posedge clk); @(negedge clk);
        check_vec("R1 reset grant", grant_o, 32'h0);
        check_vec("R1 reset use_rc", use_rc_o, 32'h0);
        req_i = '0; cache_i = '0;
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check_vec("R1 idle after reset", grant_o, 32'h0);
    endtask

    task automatic t_single();
        apply("R3 single cache entry", 32'h0000_0100, 32'h0000_0100);
        check_vec("R3 single uses cache", use_rc_o, 32'h0000_0100);
        apply("R4 single full entry", 32'h8000_0000, 32'h0);
        check_vec("R4 single uses full", use_rc_o, 32'h0);
    endtask

    task automatic t_all_cache();
        // All eligible: entries 0..4 cache, 5..7 full, rest not granted.
        apply("R5 all cache-eligible", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check_vec("R5 grant count", grant_o, 32'h0000_00FF);
        check_vec("R4 overflow to full", use_rc_o, 32'h0000_001F);
    endtask

    task automatic t_block();
        // Entries 0..3 not eligible; entry 3 finds full file exhausted.
        apply("R6 stall hides later", 32'h0000_00FF, 32'h0000_00F0);
        check_vec("R6 blocked grant", grant_o, 32'h0000_0007);
    endtask

    task automatic t_sparse();
        apply("R2 sparse cross-leaf", 32'h8002_0210, 32'h8000_0010);
        apply("R2 mixed pattern", 32'hA5A5_5A5A, 32'h0F0F_3C3C);
        apply("R2 no request", 32'h0, 32'hFFFF_FFFF);
        check_vec("R8 idle choice", use_rc_o, 32'h0);
    endtask

    task automatic t_cycles();
        // Back-to-back: budgets must not leak from the previous cycle.
        apply("R7 heavy cycle", 32'hFFFF_FFFF, 32'h0);
        apply("R7 next cycle fresh", 32'h0000_F000, 32'h0000_F000);
        check_vec("R7 fresh cache pairs", use_rc_o, 32'h0000_F000);
        apply("R3 R4 interleaved", 32'hFFFF_0000, 32'h5555_0000);
    endtask

    initial begin
        t_reset();
        t_single();
        t_all_cache();
        t_block();
        t_sparse();
        t_cycles();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule